// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox that sits between a host processor and a companion control processor. The host fills a small outgoing data buffer and sets two address pointers. It then writes a packed command word. The write latches the command, marks the mailbox busy and rings a doorbell toward the control processor. The control processor reads the latched command, the outgoing buffer and the pointers through dedicated responder ports. It can place response words in an incoming buffer, and it finishes the exchange with a one-cycle completion strobe that carries an error flag and an error code.

The host polls a status word until the busy bit drops, then reads the error flag, the error code, the echoed command id and the response words. If the command asked for an interrupt on completion, a host interrupt line rises when the command completes and falls when the host reads status.

A three-state controller sequences the exchange. The states are IDLE, RING and WAIT, with these transitions:
- IDLE→RING on an accepted command write.
- RING→WAIT when no completion arrives during the doorbell cycle.
- RING→IDLE when the completion arrives during the doorbell cycle.
- WAIT→IDLE on the completion strobe.
- Every other case holds the current state.

Top module: `mbox_top`

## Requirements
- R1: Register offsets are fixed: command at 0x00, status at 0x04, source pointer at 0x08, destination pointer at 0x0C, outgoing buffer at 0x80–0x8F and incoming buffer at 0x90–0x9F. A buffer word is selected by address bits [3:2], and each word is 32 bits wide in little-endian byte order.
- R2: An accepted command word is unpacked onto the responder ports as follows: opcode from bits [7:0], interrupt-on-completion from bit 8, command id from bits [15:12] and payload size from bits [23:16]. Bits [11:9] and [31:24] are ignored.
- R3: The status word reads as {8'h00, error code, HOST_ID, echoed id[3:0], 1'b0, overrun, error, busy}. Busy is bit 0, error is bit 1 and overrun is bit 2.
- R4: A command write in IDLE is accepted at the clock edge that samples it. Busy reads as 1 from that edge on, and the doorbell is high for exactly the one following cycle (the RING state).
- R5: Busy stays set until a completion strobe arrives, including a strobe that arrives in the doorbell cycle. A strobe while idle changes nothing.
- R6: A completion latches the error flag, the error code and an echo of the command id. Accepting a new command clears the error flag and the error code and leaves the echo unchanged.
- R7: A command write while busy is ignored: the latched fields are unchanged and no doorbell follows. It also sets a sticky overrun status bit that only reset clears.
- R8: Writes to the outgoing buffer or to either pointer are ignored while busy. While idle they appear on the responder ports one cycle later.
- R9: A completion of a command that had interrupt-on-completion set raises the host interrupt in the next cycle. A status read clears the interrupt. A command without the flag never raises it.
- R10: Read data appears on the cycle after the read strobe. Reads of the command register, the pointers, the outgoing buffer or unmapped space return zero. Reads of the incoming buffer return the words the responder loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | 8 | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 32 | Host read data, registered |
| h_irq | output | 1 | Host completion interrupt |
| r_doorbell | output | 1 | One-cycle command notification to the responder |
| r_opcode | output | 8 | Latched command opcode |
| r_ioc | output | 1 | Latched interrupt-on-completion flag |
| r_cmd_id | output | 4 | Latched command id |
| r_size | output | 8 | Latched payload size in bytes |
| r_src_ptr | output | 32 | Source pointer |
| r_dst_ptr | output | 32 | Destination pointer |
| r_wbuf_idx | input | 2 | Outgoing buffer word select |
| r_wbuf_data | output | 32 | Selected outgoing buffer word |
| r_rbuf_we | input | 1 | Incoming buffer word write enable |
| r_rbuf_idx | input | 2 | Incoming buffer word select |
| r_rbuf_data | input | 32 | Incoming buffer word to store |
| r_done | input | 1 | Completion strobe |
| r_err | input | 1 | Error flag sampled with r_done |
| r_err_code | input | 8 | Error code sampled with r_done |

## Verification
Each bus write completes at a falling edge. Busy, the doorbell and the latched fields are sampled at the first falling edge after the rising edge that takes the write. The doorbell is checked low again one cycle later. Read data is due one cycle after the read strobe, so a monitor checks each queued expected value at the falling edge after the rising edge that registered the strobe. The interrupt is sampled at the falling edge after the completion edge, and again after the status read that clears it.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RING = 2'd1,
        ST_WAIT = 2'd2
    } mbox_state_e;

    typedef struct packed {
        logic [7:0] size;
        logic [3:0] id;
        logic       ioc;
        logic [7:0] opcode;
    } mbox_cmd_t;

    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_SPTR = 8'h08;
    localparam logic [7:0] OFS_DPTR = 8'h0C;
    localparam logic [7:0] OFS_WBUF = 8'h80;
    localparam logic [7:0] OFS_RBUF = 8'h90;

    function automatic mbox_cmd_t unpack_cmd(input logic [31:0] w);
        mbox_cmd_t c;
        c.opcode = w[7:0];
        c.ioc    = w[8];
        c.id     = w[15:12];
        c.size   = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/mbox_fsm.sv
module mbox_fsm
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic done,
    output logic accept,
    output logic finish,
    output logic busy,
    output logic doorbell
);

    mbox_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_wr) state_nx = ST_RING;
            ST_RING: state_nx = done ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (done)   state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        doorbell = (state == ST_RING);
        accept   = (state == ST_IDLE) && cmd_wr;
        finish   = (state != ST_IDLE) && done;
    end

endmodule

// File: rtl/mbox_buf.sv
module mbox_buf #(
    parameter int WORDS = 4,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [DW-1:0] rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                           mem[g] <= '0;
            else if (we && widx == IW'(g))        mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/mbox_top.sv
module mbox_top
    import mbox_pkg::*;
#(
    parameter int         BUF_BYTES = 16,
    parameter logic [7:0] HOST_ID   = 8'h01,
    localparam int        WORDS     = BUF_BYTES / 4,
    localparam int        IW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    h_addr,
    input  logic          h_wr,
    input  logic [31:0]   h_wdata,
    input  logic          h_rd,
    output logic [31:0]   h_rdata,
    output logic          h_irq,
    output logic          r_doorbell,
    output logic [7:0]    r_opcode,
    output logic          r_ioc,
    output logic [3:0]    r_cmd_id,
    output logic [7:0]    r_size,
    output logic [31:0]   r_src_ptr,
    output logic [31:0]   r_dst_ptr,
    input  logic [IW-1:0] r_wbuf_idx,
    output logic [31:0]   r_wbuf_data,
    input  logic          r_rbuf_we,
    input  logic [IW-1:0] r_rbuf_idx,
    input  logic [31:0]   r_rbuf_data,
    input  logic          r_done,
    input  logic          r_err,
    input  logic [7:0]    r_err_code
);

    localparam logic [7:0] BUF_MASK = 8'(BUF_BYTES - 1);

    // address decode
    logic sel_cmd, sel_stat, sel_sptr, sel_dptr, sel_wbuf, sel_rbuf;
    logic [IW-1:0] word_idx;

    assign sel_cmd  = (h_addr == OFS_CMD);
    assign sel_stat = (h_addr == OFS_STAT);
    assign sel_sptr = (h_addr == OFS_SPTR);
    assign sel_dptr = (h_addr == OFS_DPTR);
    assign sel_wbuf = ((h_addr & ~BUF_MASK) == OFS_WBUF);
    assign sel_rbuf = ((h_addr & ~BUF_MASK) == OFS_RBUF);
    assign word_idx = h_addr[IW+1:2];

    logic unused_bits;
    assign unused_bits = ^{h_addr[1:0], h_wdata[31:24], h_wdata[11:9]};

    // controller
    logic accept, finish, busy;

    mbox_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (h_wr && sel_cmd),
        .done     (r_done),
        .accept   (accept),
        .finish   (finish),
        .busy     (busy),
        .doorbell (r_doorbell)
    );

    // command and pointers
    mbox_cmd_t cmd_q;
    logic [31:0] sptr_q, dptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            sptr_q <= '0;
            dptr_q <= '0;
        end else begin
            if (accept)                     cmd_q  <= unpack_cmd(h_wdata);
            if (h_wr && sel_sptr && !busy)  sptr_q <= h_wdata;
            if (h_wr && sel_dptr && !busy)  dptr_q <= h_wdata;
        end
    end

    assign r_opcode  = cmd_q.opcode;
    assign r_ioc     = cmd_q.ioc;
    assign r_cmd_id  = cmd_q.id;
    assign r_size    = cmd_q.size;
    assign r_src_ptr = sptr_q;
    assign r_dst_ptr = dptr_q;

    // buffers
    logic [31:0] wbuf_host_unused, rbuf_host, rbuf_resp_unused;

    mbox_buf #(.WORDS(WORDS), .DW(32)) i_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (h_wr && sel_wbuf && !busy),
        .widx    (word_idx),
        .wdata   (h_wdata),
        .ridx_a  (r_wbuf_idx),
        .rdata_a (r_wbuf_data),
        .ridx_b  (word_idx),
        .rdata_b (wbuf_host_unused)
    );

    mbox_buf #(.WORDS(WORDS), .DW(32)) i_rbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (r_rbuf_we),
        .widx    (r_rbuf_idx),
        .wdata   (r_rbuf_data),
        .ridx_a  (word_idx),
        .rdata_a (rbuf_host),
        .ridx_b  (r_rbuf_idx),
        .rdata_b (rbuf_resp_unused)
    );

    // completion status
    logic       err_q, ovr_q, irq_q;
    logic [7:0] code_q;
    logic [3:0] echo_q;
    logic       stat_rd;

    assign stat_rd = h_rd && sel_stat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            code_q <= '0;
            echo_q <= '0;
            ovr_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (accept) begin
                err_q  <= 1'b0;
                code_q <= '0;
            end else if (finish) begin
                err_q  <= r_err;
                code_q <= r_err_code;
                echo_q <= cmd_q.id;
            end
            if (h_wr && sel_cmd && busy) ovr_q <= 1'b1;
            if (finish && cmd_q.ioc)     irq_q <= 1'b1;
            else if (stat_rd)            irq_q <= 1'b0;
        end
    end

    assign h_irq = irq_q;

    // registered read path
    logic [31:0] status_w, rd_mux;

    assign status_w = {8'h00, code_q, HOST_ID, echo_q, 1'b0, ovr_q, err_q, busy};

    always_comb begin
        rd_mux = '0;
        if (sel_stat)      rd_mux = status_w;
        else if (sel_rbuf) rd_mux = rbuf_host;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    h_rdata <= '0;
        else if (h_rd) h_rdata <= rd_mux;
    end

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       busy,
    input logic       doorbell,
    input logic       done,
    input logic       ioc,
    input logic       irq,
    input logic       ovr,
    input logic [7:0] opcode
);

    p_busy_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (busy && doorbell));

    p_doorbell_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);

    p_overrun_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> (ovr && $stable(opcode) && !doorbell));

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr);

    p_irq_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && ioc) |=> irq);

endmodule

bind mbox_top mbox_chk i_mbox_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (h_wr && sel_cmd),
    .busy     (busy),
    .doorbell (r_doorbell),
    .done     (r_done),
    .ioc      (r_ioc),
    .irq      (h_irq),
    .ovr      (ovr_q),
    .opcode   (r_opcode)
);

// File: tb/test_mbox_top.sv
module test_mbox_top;

    localparam logic [7:0] HID = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  h_addr = '0;
    logic        h_wr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic        h_rd = 1'b0;
    logic [31:0] h_rdata;
    logic        h_irq, r_doorbell, r_ioc;
    logic [7:0]  r_opcode, r_size;
    logic [3:0]  r_cmd_id;
    logic [31:0] r_src_ptr, r_dst_ptr, r_wbuf_data;
    logic [1:0]  r_wbuf_idx = '0;
    logic        r_rbuf_we = 1'b0;
    logic [1:0]  r_rbuf_idx = '0;
    logic [31:0] r_rbuf_data = '0;
    logic        r_done = 1'b0, r_err = 1'b0;
    logic [7:0]  r_err_code = '0;

    always #2 clk = ~clk;

    mbox_top #(.BUF_BYTES(16), .HOST_ID(HID)) i_mbox_top (.*);

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic rd_seen = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: a read registered at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_seen <= h_rd;
    always @(negedge clk) begin
        if (rd_seen && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, h_rdata, e.v);
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.v = exp; e.tag = tag;
        sb.push_back(e);
        h_addr = a; h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic complete(input logic e, input logic [7:0] c);
        @(negedge clk);
        r_done = 1'b1; r_err = e; r_err_code = c;
        @(negedge clk);
        r_done = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset status layout with HOST_ID
        bus_rd(8'h04, 32'h00005A00, "R3 reset status");
        check("R9 irq at reset", 32'(h_irq), 32'h0);

        // R8 idle writes to buffer and pointers, R1 little-endian words by addr[3:2]
        bus_wr(8'h80, 32'h11223344);
        bus_wr(8'h84, 32'h55667788);
        bus_wr(8'h88, 32'h99AABBCC);
        bus_wr(8'h8C, 32'hDDEEFF00);
        bus_wr(8'h08, 32'hCAFE0001);
        bus_wr(8'h0C, 32'hBEEF0002);
        r_wbuf_idx = 2'd2; #0;
        check("R8 R1 wbuf word2", r_wbuf_data, 32'h99AABBCC);
        check("R8 src ptr", r_src_ptr, 32'hCAFE0001);
        check("R8 dst ptr", r_dst_ptr, 32'hBEEF0002);

        // R10 write-only reads return zero
        bus_rd(8'h08, 32'h0, "R10 sptr reads zero");
        bus_rd(8'h84, 32'h0, "R10 wbuf reads zero");

        // R2 R4 command accepted: ioc=1 id=7 size=12 opcode=3C, reserved bits set
        bus_wr(8'h00, 32'hFF0C7F3C);
        check("R4 doorbell after accept", 32'(r_doorbell), 32'h1);
        check("R2 opcode", 32'(r_opcode), 32'h3C);
        check("R2 ioc", 32'(r_ioc), 32'h1);
        check("R2 cmd id", 32'(r_cmd_id), 32'h7);
        check("R2 size", 32'(r_size), 32'h0C);
        @(negedge clk);
        check("R4 doorbell one cycle", 32'(r_doorbell), 32'h0);
        bus_rd(8'h04, 32'h00005A01, "R4 R5 busy status");

        // R7 overrun
        bus_wr(8'h00, 32'h00045011);
        check("R7 no doorbell on overrun", 32'(r_doorbell), 32'h0);
        check("R7 opcode kept", 32'(r_opcode), 32'h3C);
        bus_rd(8'h04, 32'h00005A05, "R7 overrun bit");

        // R8 buffer write while busy ignored
        bus_wr(8'h80, 32'h0BADF00D);
        r_wbuf_idx = 2'd0; #0;
        check("R8 busy wbuf write ignored", r_wbuf_data, 32'h11223344);

        // responder loads incoming buffer
        @(negedge clk);
        r_rbuf_we = 1'b1; r_rbuf_idx = 2'd1; r_rbuf_data = 32'hA5A5_0101;
        @(negedge clk);
        r_rbuf_idx = 2'd3; r_rbuf_data = 32'h5A5A_0303;
        @(negedge clk);
        r_rbuf_we = 1'b0;

        // R5 R6 R9 completion with error
        complete(1'b1, 8'h42);
        check("R9 irq after ioc completion", 32'(h_irq), 32'h1);
        bus_rd(8'h04, 32'h00425A76, "R6 completion status");
        check("R9 irq cleared by status read", 32'(h_irq), 32'h0);
        bus_rd(8'h94, 32'hA5A50101, "R10 rbuf word1");
        bus_rd(8'h9C, 32'h5A5A0303, "R10 rbuf word3");
        bus_rd(8'h00, 32'h0, "R10 cmd reads zero");

        // R6 accept clears error, R9 no irq without ioc
        bus_wr(8'h00, 32'h00043011);
        bus_rd(8'h04, 32'h00005A75, "R6 accept clears error");
        complete(1'b0, 8'h00);
        check("R9 no irq without ioc", 32'(h_irq), 32'h0);
        bus_rd(8'h04, 32'h00005A34, "R6 second completion");

        // R5 completion while idle ignored
        complete(1'b1, 8'h99);
        bus_rd(8'h04, 32'h00005A34, "R5 idle done ignored");

        // R5 completion in the doorbell cycle
        bus_wr(8'h00, 32'h0001A022);
        r_done = 1'b1; r_err = 1'b0; r_err_code = 8'h00;
        @(negedge clk);
        r_done = 1'b0;
        bus_rd(8'h04, 32'h00005AA4, "R5 done in ring cycle");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule